// File: doc/BRIEF.md
# Link Management Polling Engine

This block automates the link-integrity exchange on the management channel of a frame-relay style link running in bidirectional mode. A programmable timer, advanced by an external tick, paces the outgoing status enquiries. A programmable count decides whether each enquiry asks only for link integrity or for a full status report. The receive path reports the type of each management frame it decodes. Integrity-only enquiries from the far end are answered at once by the block itself, and each one restarts the timer.

Traffic the block cannot finish alone goes to the host as numbered primitive events. These are full and asynchronous status reports, and full-status enquiries from the far end. Through a primitive input the host asks for a full status reply to be sent, or for an asynchronous status frame to go out. Framing, CRC and frame storage belong to the surrounding datapath. This block only issues one-cycle transmit requests tagged with the kind of frame to build.

Top module: `link_poll_engine`

## Requirements
- R1: After a synchronous reset, `tx_req`, `evt_valid` and `overrun` are 0.
- R2: A received integrity-only enquiry (`rx_type`=1) causes `tx_req` with `tx_kind`=3 (integrity-only status reply) in the second cycle after the one with `rx_valid`. It raises no event.
- R3: A received integrity-only enquiry restarts the poll timer with `t2_load`. With `tick` high every cycle, the next enquiry request comes 9 cycles after the reply request.
- R4: A received full-status enquiry (`rx_type`=2) raises an event with code 13 and parameter 1 one cycle later and sends nothing. A later host primitive 11 with parameter 0 causes `tx_req` with `tx_kind`=4 (full status reply) two cycles after it.
- R5: A host primitive 11 with parameter 0 while no full-status enquiry is waiting, and any host primitive code other than 11, cause no transmit request and no event.
- R6: A host primitive 11 with parameter 2 causes `tx_req` with `tx_kind`=5 (asynchronous status) two cycles later.
- R7: A received full status frame (`rx_type`=4) raises event 13 with parameter 0. A received asynchronous status frame (`rx_type`=5) raises event 14 with parameter 0. Received integrity-only status frames (`rx_type`=3) and all other types raise nothing.
- R8: The first `n391_cfg` enquiries after reset carry `tx_kind`=1 (integrity-only), and the next one carries `tx_kind`=2 (full status). The count then starts over.
- R9: With `poll_en` high and `tick` high every cycle, enquiry requests come every `t2_load` cycles. With `poll_en` low, no enquiry is sent.
- R10: A full-status enquiry received while an earlier one still waits for the host sets `overrun`, which stays set until reset. It raises no event and adds no second full reply.
- R11: When several transmissions are due in the same cycle, they are issued one per cycle in this order: integrity-only reply, full reply, asynchronous status, enquiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Allows timer expiry to send enquiries |
| n391_cfg | input | 8 | Integrity-only enquiries between full-status enquiries |
| t2_load | input | 16 | Poll timer reload value in ticks |
| tick | input | 1 | Timer advance strobe |
| rx_valid | input | 1 | A management frame type is presented |
| rx_type | input | 3 | 1 enq-integrity, 2 enq-full, 3 status-integrity, 4 status-full, 5 status-async |
| host_valid | input | 1 | Host primitive strobe |
| host_code | input | 4 | Host primitive number (11 = status request) |
| host_parm | input | 2 | Host primitive parameter (0 full, 2 async) |
| tx_req | output | 1 | One-cycle transmit request |
| tx_kind | output | 3 | 1 enq-integrity, 2 enq-full, 3 reply-integrity, 4 reply-full, 5 async status |
| evt_valid | output | 1 | One-cycle event to host |
| evt_code | output | 4 | Event number (13 or 14) |
| evt_parm | output | 2 | Event parameter |
| overrun | output | 1 | Sticky full-enquiry overrun flag |

## Verification
Every received frame type and every host primitive variant is applied alone, with polling off. This separates the frames the block answers itself from those it passes to the host and from those it drops, and it shows that a release request is only honoured while a full enquiry is waiting. With free-running polling, the run checks both the kind sequence and the spacing of the enquiries. That shows the count-based choice of kind is separate from the timer period. A reply injected in mid-period then shows the timer restart through the longer gap that follows. Back-to-back full enquiries and a combined reply-plus-async request cover the overrun path and the issue order.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  localparam int CODE_W = 3;
  localparam int PRIM_W = 4;
  localparam int PARM_W = 2;

  // received frame classes
  localparam logic [CODE_W-1:0] RX_ENQ_LIV  = 3'd1;
  localparam logic [CODE_W-1:0] RX_ENQ_FULL = 3'd2;
  localparam logic [CODE_W-1:0] RX_STS_LIV  = 3'd3;
  localparam logic [CODE_W-1:0] RX_STS_FULL = 3'd4;
  localparam logic [CODE_W-1:0] RX_STS_ASYN = 3'd5;

  // transmit kinds
  typedef enum logic [CODE_W-1:0] {
    TX_NONE     = 3'd0,
    TX_ENQ_LIV  = 3'd1,
    TX_ENQ_FULL = 3'd2,
    TX_RSP_LIV  = 3'd3,
    TX_RSP_FULL = 3'd4,
    TX_STS_ASYN = 3'd5
  } tx_kind_e;

  // request slots, index is priority (0 highest)
  localparam int SLOT_RSP_LIV  = 0;
  localparam int SLOT_RSP_FULL = 1;
  localparam int SLOT_ASYNC    = 2;
  localparam int SLOT_ENQ      = 3;
  localparam int NSLOT         = 4;

  localparam logic [PRIM_W-1:0] PRIM_STATUS_REQ = 4'd11;
  localparam logic [PRIM_W-1:0] EVT_FULL        = 4'd13;
  localparam logic [PRIM_W-1:0] EVT_ASYNC       = 4'd14;
  localparam logic [PARM_W-1:0] PARM_FULL       = 2'd0;
  localparam logic [PARM_W-1:0] PARM_ASYNC      = 2'd2;
endpackage

// File: rtl/lpe_t2_timer.sv
module lpe_t2_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [TMR_W-1:0] load,
  output logic             expire
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= load;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (restart) begin
        cnt <= load;
      end else if (tick) begin
        if (cnt <= TMR_W'(1)) begin
          cnt    <= load;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - TMR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lpe_poll_sched.sv
module lpe_poll_sched #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             poll_en,
  input  logic [CNT_W-1:0] n391,
  input  logic             grant,
  output logic             pend,
  output logic             full
);
  logic [CNT_W-1:0] liv_sent;

  assign full = (liv_sent >= n391);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      liv_sent <= '0;
    end else begin
      if (expire && poll_en) pend <= 1'b1;
      else if (grant)        pend <= 1'b0;
      if (grant) begin
        if (full) liv_sent <= '0;
        else      liv_sent <= liv_sent + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lpe_tx_arb.sv
module lpe_tx_arb
  import lpe_pkg::*;
#(
  parameter int N = NSLOT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req,
  input  logic              enq_full,
  output logic [N-1:0]      grant,
  output logic              tx_req,
  output logic [CODE_W-1:0] tx_kind
);
  logic [N-1:0] blocked;

  // fixed priority: lower index wins
  always_comb begin
    blocked[0] = 1'b0;
    for (int i = 1; i < N; i++) blocked[i] = blocked[i-1] | req[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      assign grant[g] = req[g] & ~blocked[g];
    end
  endgenerate

  tx_kind_e kind_nxt;
  always_comb begin
    kind_nxt = TX_NONE;
    if (grant[SLOT_RSP_LIV])       kind_nxt = TX_RSP_LIV;
    else if (grant[SLOT_RSP_FULL]) kind_nxt = TX_RSP_FULL;
    else if (grant[SLOT_ASYNC])    kind_nxt = TX_STS_ASYN;
    else if (grant[SLOT_ENQ])      kind_nxt = enq_full ? TX_ENQ_FULL : TX_ENQ_LIV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req  <= 1'b0;
      tx_kind <= TX_NONE;
    end else begin
      tx_req  <= |req;
      tx_kind <= kind_nxt;
    end
  end
endmodule

// File: rtl/lpe_host_if.sv
module lpe_host_if
  import lpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_type,
  input  logic              host_valid,
  input  logic [PRIM_W-1:0] host_code,
  input  logic [PARM_W-1:0] host_parm,
  input  logic              grant_liv,
  input  logic              grant_full,
  input  logic              grant_async,
  output logic              pend_liv,
  output logic              pend_full,
  output logic              pend_async,
  output logic              restart,
  output logic              evt_valid,
  output logic [PRIM_W-1:0] evt_code,
  output logic [PARM_W-1:0] evt_parm,
  output logic              overrun
);
  logic wait_full;
  logic liv_enq, full_enq, sts_full, sts_async;
  logic host_req, release_full, async_req;

  assign liv_enq      = rx_valid && (rx_type == RX_ENQ_LIV);
  assign full_enq     = rx_valid && (rx_type == RX_ENQ_FULL);
  assign sts_full     = rx_valid && (rx_type == RX_STS_FULL);
  assign sts_async    = rx_valid && (rx_type == RX_STS_ASYN);
  assign host_req     = host_valid && (host_code == PRIM_STATUS_REQ);
  assign release_full = host_req && (host_parm == PARM_FULL) && wait_full;
  assign async_req    = host_req && (host_parm == PARM_ASYNC);
  assign restart      = liv_enq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_liv   <= 1'b0;
      pend_full  <= 1'b0;
      pend_async <= 1'b0;
      wait_full  <= 1'b0;
      overrun    <= 1'b0;
      evt_valid  <= 1'b0;
      evt_code   <= '0;
      evt_parm   <= '0;
    end else begin
      if (liv_enq)        pend_liv <= 1'b1;
      else if (grant_liv) pend_liv <= 1'b0;

      if (release_full)    pend_full <= 1'b1;
      else if (grant_full) pend_full <= 1'b0;

      if (async_req)        pend_async <= 1'b1;
      else if (grant_async) pend_async <= 1'b0;

      if (full_enq && !wait_full) wait_full <= 1'b1;
      else if (release_full)      wait_full <= 1'b0;

      if (full_enq && wait_full) overrun <= 1'b1;

      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_parm  <= '0;
      if (full_enq && !wait_full) begin
        evt_valid <= 1'b1;
        evt_code  <= EVT_FULL;
        evt_parm  <= 2'd1;
      end else if (sts_full) begin
        evt_valid <= 1'b1;
        evt_code  <= EVT_FULL;
      end else if (sts_async) begin
        evt_valid <= 1'b1;
        evt_code  <= EVT_ASYNC;
      end
    end
  end
endmodule

// File: rtl/link_poll_engine.sv
module link_poll_engine
  import lpe_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic [CNT_W-1:0]  n391_cfg,
  input  logic [TMR_W-1:0]  t2_load,
  input  logic              tick,
  input  logic              rx_valid,
  input  logic [2:0]        rx_type,
  input  logic              host_valid,
  input  logic [3:0]        host_code,
  input  logic [1:0]        host_parm,
  output logic              tx_req,
  output logic [2:0]        tx_kind,
  output logic              evt_valid,
  output logic [3:0]        evt_code,
  output logic [1:0]        evt_parm,
  output logic              overrun
);
  logic [NSLOT-1:0] req, grant;
  logic expire, restart, enq_full;

  lpe_t2_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .load(t2_load), .expire(expire)
  );

  lpe_poll_sched #(.CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst(rst), .expire(expire), .poll_en(poll_en),
    .n391(n391_cfg), .grant(grant[SLOT_ENQ]),
    .pend(req[SLOT_ENQ]), .full(enq_full)
  );

  lpe_host_if u_host (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_type(rx_type),
    .host_valid(host_valid), .host_code(host_code), .host_parm(host_parm),
    .grant_liv(grant[SLOT_RSP_LIV]), .grant_full(grant[SLOT_RSP_FULL]),
    .grant_async(grant[SLOT_ASYNC]),
    .pend_liv(req[SLOT_RSP_LIV]), .pend_full(req[SLOT_RSP_FULL]),
    .pend_async(req[SLOT_ASYNC]),
    .restart(restart),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_parm(evt_parm),
    .overrun(overrun)
  );

  lpe_tx_arb #(.N(NSLOT)) u_arb (
    .clk(clk), .rst(rst), .req(req), .enq_full(enq_full),
    .grant(grant), .tx_req(tx_req), .tx_kind(tx_kind)
  );
endmodule

// File: rtl/link_poll_engine_chk.sv
module link_poll_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic [2:0] rx_type,
  input logic       host_valid,
  input logic       tx_req,
  input logic [2:0] tx_kind,
  input logic       evt_valid,
  input logic [3:0] evt_code,
  input logic       overrun
);
  AST_LIV_AUTO_REPLY: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_type == 3'd1) |=> ##1 (tx_req && tx_kind == 3'd3)); // R2

  AST_LIV_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (rx_type == 3'd1 || rx_type == 3'd3)) |=> !evt_valid); // R7

  AST_EVT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_code == 4'd13 || evt_code == 4'd14)); // R7

  AST_HOST_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !rx_valid) |=> !evt_valid); // R5

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R10

  AST_TX_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (tx_kind >= 3'd1 && tx_kind <= 3'd5)); // R11
endmodule

bind link_poll_engine link_poll_engine_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_type(rx_type),
  .host_valid(host_valid), .tx_req(tx_req), .tx_kind(tx_kind),
  .evt_valid(evt_valid), .evt_code(evt_code), .overrun(overrun)
);

// File: tb/tb_link_poll_engine.sv
`timescale 1ns/1ps
module tb_link_poll_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic poll_en = 1'b0;
  logic [7:0] n391_cfg = 8'd2;
  logic [15:0] t2_load = 16'd3;
  logic tick = 1'b0;
  logic rx_valid = 1'b0;
  logic [2:0] rx_type = 3'd0;
  logic host_valid = 1'b0;
  logic [3:0] host_code = 4'd0;
  logic [1:0] host_parm = 2'd0;
  logic tx_req, evt_valid, overrun;
  logic [2:0] tx_kind;
  logic [3:0] evt_code;
  logic [1:0] evt_parm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  link_poll_engine dut (
    .clk(clk), .rst(rst), .poll_en(poll_en), .n391_cfg(n391_cfg),
    .t2_load(t2_load), .tick(tick), .rx_valid(rx_valid), .rx_type(rx_type),
    .host_valid(host_valid), .host_code(host_code), .host_parm(host_parm),
    .tx_req(tx_req), .tx_kind(tx_kind), .evt_valid(evt_valid),
    .evt_code(evt_code), .evt_parm(evt_parm), .overrun(overrun)
  );

  typedef struct packed {
    logic [2:0] rx;
    logic       hv;
    logic [3:0] hc;
    logic [1:0] hp;
    logic       etx;
    logic [2:0] ekind;
    logic       eev;
    logic [3:0] ecode;
    logic [1:0] eparm;
    logic [3:0] rid;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 4'd0,  2'd0, 1'b1, 3'd3, 1'b0, 4'd0,  2'd0, 4'd2},  // R2 integrity enquiry
    '{3'd4, 1'b0, 4'd0,  2'd0, 1'b0, 3'd0, 1'b1, 4'd13, 2'd0, 4'd7},  // R7 full status
    '{3'd5, 1'b0, 4'd0,  2'd0, 1'b0, 3'd0, 1'b1, 4'd14, 2'd0, 4'd7},  // R7 async status
    '{3'd3, 1'b0, 4'd0,  2'd0, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 4'd7},  // R7 integrity status
    '{3'd2, 1'b0, 4'd0,  2'd0, 1'b0, 3'd0, 1'b1, 4'd13, 2'd1, 4'd4},  // R4 full enquiry
    '{3'd0, 1'b1, 4'd11, 2'd0, 1'b1, 3'd4, 1'b0, 4'd0,  2'd0, 4'd4},  // R4 host release
    '{3'd0, 1'b1, 4'd11, 2'd0, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 4'd5},  // R5 release w/o wait
    '{3'd0, 1'b1, 4'd11, 2'd2, 1'b1, 3'd5, 1'b0, 4'd0,  2'd0, 4'd6},  // R6 async request
    '{3'd0, 1'b1, 4'd12, 2'd0, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 4'd5},  // R5 other code
    '{3'd6, 1'b0, 4'd0,  2'd0, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 4'd7}   // R7 unknown type
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive for one cycle; returns at the negedge after the sampling edge
  task automatic pulse(input logic rv, input logic [2:0] rt, input logic hv,
                       input logic [3:0] hc, input logic [1:0] hp);
    rx_valid = rv; rx_type = rt;
    host_valid = hv; host_code = hc; host_parm = hp;
    @(negedge clk);
    rx_valid = 1'b0; rx_type = 3'd0;
    host_valid = 1'b0; host_code = 4'd0; host_parm = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  int kinds [6];
  int gaps [6];
  int nseen;
  int cyc;
  int last;

  initial begin
    // R1 reset state
    do_reset();
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);
    chk(evt_valid == 1'b0, "R1 evt_valid", evt_valid, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);

    // table walk, polling off
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i].rx != 3'd0, VEC[i].rx, VEC[i].hv, VEC[i].hc, VEC[i].hp);
      chk(evt_valid == VEC[i].eev && (!VEC[i].eev ||
          (evt_code == VEC[i].ecode && evt_parm == VEC[i].eparm)),
          $sformatf("R%0d event row %0d", VEC[i].rid, i),
          {evt_valid, evt_code, evt_parm}, {VEC[i].eev, VEC[i].ecode, VEC[i].eparm});
      @(negedge clk);
      chk(tx_req == VEC[i].etx && (!VEC[i].etx || tx_kind == VEC[i].ekind),
          $sformatf("R%0d tx row %0d", VEC[i].rid, i),
          {tx_req, tx_kind}, {VEC[i].etx, VEC[i].ekind});
      @(negedge clk);
    end

    // R10 overrun: second full enquiry while waiting
    do_reset();
    pulse(1'b1, 3'd2, 1'b0, 4'd0, 2'd0);
    chk(evt_valid && evt_code == 4'd13 && evt_parm == 2'd1, "R4 first full enq event",
        {evt_valid, evt_code, evt_parm}, {1'b1, 4'd13, 2'd1});
    @(negedge clk);
    pulse(1'b1, 3'd2, 1'b0, 4'd0, 2'd0);
    chk(evt_valid == 1'b0, "R10 no second event", evt_valid, 0);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    @(negedge clk);
    pulse(1'b0, 3'd0, 1'b1, 4'd11, 2'd0);
    @(negedge clk);
    chk(tx_req && tx_kind == 3'd4, "R4 full reply after release", {tx_req, tx_kind}, {1'b1, 3'd4});
    nseen = 0;
    repeat (4) begin
      @(negedge clk);
      if (tx_req) nseen++;
    end
    pulse(1'b0, 3'd0, 1'b1, 4'd11, 2'd0);
    @(negedge clk);
    if (tx_req) nseen++;
    chk(nseen == 0, "R10 single full reply", nseen, 0);
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

    // R11 priority: integrity reply ahead of async status
    do_reset();
    pulse(1'b1, 3'd1, 1'b1, 4'd11, 2'd2);
    @(negedge clk);
    chk(tx_req && tx_kind == 3'd3, "R11 first issued", {tx_req, tx_kind}, {1'b1, 3'd3});
    @(negedge clk);
    chk(tx_req && tx_kind == 3'd5, "R11 second issued", {tx_req, tx_kind}, {1'b1, 3'd5});

    // R9 polling disabled: no enquiries
    t2_load = 16'd3; n391_cfg = 8'd2; poll_en = 1'b0;
    do_reset();
    tick = 1'b1;
    nseen = 0;
    repeat (40) begin
      @(negedge clk);
      if (tx_req) nseen++;
    end
    chk(nseen == 0, "R9 no enquiry when disabled", nseen, 0);

    // R8 / R9 enquiry kinds and spacing
    tick = 1'b0;
    do_reset();
    poll_en = 1'b1; tick = 1'b1;
    nseen = 0; cyc = 0; last = 0;
    while (nseen < 6 && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (tx_req) begin
        kinds[nseen] = tx_kind;
        gaps[nseen] = cyc - last;
        last = cyc;
        nseen++;
      end
    end
    chk(nseen == 6, "R9 enquiries seen", nseen, 6);
    for (int i = 0; i < 6; i++) begin
      int ek;
      ek = ((i % 3) == 2) ? 2 : 1;
      chk(kinds[i] == ek, $sformatf("R8 kind %0d", i), kinds[i], ek);
      if (i > 0) chk(gaps[i] == 3, $sformatf("R9 gap %0d", i), gaps[i], 3);
    end

    // R3 restart by integrity enquiry
    poll_en = 1'b0; tick = 1'b0; t2_load = 16'd8;
    do_reset();
    poll_en = 1'b1; tick = 1'b1;
    cyc = 0;
    while (!tx_req && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(tx_req && tx_kind == 3'd1, "R3 first enquiry", {tx_req, tx_kind}, {1'b1, 3'd1});
    pulse(1'b1, 3'd1, 1'b0, 4'd0, 2'd0);
    @(negedge clk);
    chk(tx_req && tx_kind == 3'd3, "R3 reply", {tx_req, tx_kind}, {1'b1, 3'd3});
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!tx_req && cyc < 50);
    chk(cyc == 9, "R3 gap after restart", cyc, 9);
    chk(tx_kind == 3'd1, "R8 second enquiry kind", tx_kind, 1);

    tick = 1'b0; poll_en = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule